// File: doc/BRIEF.md
# Interrupt Distributor Global Register Group

This block is the small global register group at the base of an interrupt distributor. It sits on a plain 32-bit register bus with separate read and write strobes. It holds the single bit that turns the whole distributor on. It also answers two read-only words. One is a capability word that reports how many interrupt lines the distributor handles and how many processors hang off it. The other is a fixed identification word carrying a product code and an implementer code.

The enable bit is also driven out as a level. When software turns the distributor on from the off state, the block raises a one-clock wake pulse. The pulse lets every attached processor re-examine its pending work. A write that rewrites an already-set enable produces no pulse.

The shared-line count, processor count and both identification codes are build-time parameters. Read data is registered and appears one clock after the read strobe.

Top module: `dist_glob_regs`

## Requirements
- R1: While reset is high and in the first cycle after it, `dist_enable`, `wake_pulse` and `bus_rdata` are all 0.
- R2: A write at word offset 0 (address bits [3:2] = 0) stores write-data bit 0 as the enable. Reading offset 0 returns the enable in bit 0 and zero in bits [31:1].
- R3: A control write that sets the enable while it is cleared raises `wake_pulse` for exactly one clock, in the cycle after the write.
- R4: A control write that leaves the enable set, clears it, or writes 0 to a cleared enable leaves `wake_pulse` low.
- R5: Reading offset 1 returns the capability word. Bits [4:0] hold ((NUM_SHARED + 32) / 32) − 1, bits [7:5] hold NUM_CPUS − 1, and bits [31:8] are zero.
- R6: Reading offset 2 returns the identification word, with PRODUCT_CODE in bits [31:24], IMPL_CODE in bits [11:0] and zero elsewhere.
- R7: Writes to offsets 1, 2 and 3 change neither the enable, nor any read value, nor `wake_pulse`.
- R8: Reading offset 3 returns zero.
- R9: Read data is registered and appears on `bus_rdata` in the cycle after `bus_rd` is high. It holds its value while `bus_rd` is low. A read and a control write in the same cycle return the enable from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dist_enable | output | 1 | Global distributor enable level |
| wake_pulse | output | 1 | One-clock pulse on an off-to-on enable change |

## Verification
The enable is driven through every pair of old and new values: 0→1, 1→1, 1→0 and 0→0. Only the first pair may produce a pulse, which separates a true edge detector from one that fires on every write of a one. Random traffic spreads writes with random data over all four offsets and interleaves them with reads. This shows that only offset 0 holds state and that the read-only words never move. A read issued in the same cycle as a control write pins down whether the returned value is taken before or after the update.

// File: rtl/dist_glob_pkg.sv
package dist_glob_pkg;
  localparam int WORD_W = 32;

  // Word select decoded from address bits [3:2]
  typedef enum logic [1:0] {
    OFS_CTRL  = 2'd0,
    OFS_CAPS  = 2'd1,
    OFS_IDENT = 2'd2,
    OFS_SPARE = 2'd3
  } glob_ofs_e;
endpackage

// File: rtl/glob_ctrl_reg.sv
module glob_ctrl_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr_ctrl,
  input  logic wr_bit,
  output logic enable_q,
  output logic wake_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      wake_q <= wr_ctrl & wr_bit & ~enable_q;
      if (wr_ctrl) enable_q <= wr_bit;
    end
  end
endmodule

// File: rtl/glob_ident_words.sv
module glob_ident_words #(
  parameter int          NUM_SHARED   = 96,
  parameter int          NUM_CPUS     = 4,
  parameter logic [7:0]  PRODUCT_CODE = 8'h4B,
  parameter logic [11:0] IMPL_CODE    = 12'h43B
) (
  output logic [dist_glob_pkg::WORD_W-1:0] caps_word,
  output logic [dist_glob_pkg::WORD_W-1:0] ident_word
);
  localparam int         TOTAL_LINES = NUM_SHARED + 32;
  localparam logic [4:0] LINE_FIELD  = 5'(TOTAL_LINES / 32 - 1);
  localparam logic [2:0] CPU_FIELD   = 3'(NUM_CPUS - 1);

  assign caps_word  = {24'd0, CPU_FIELD, LINE_FIELD};
  assign ident_word = {PRODUCT_CODE, 12'd0, IMPL_CODE};
endmodule

// File: rtl/glob_read_port.sv
module glob_read_port (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rd,
  input  dist_glob_pkg::glob_ofs_e         ofs,
  input  logic                             enable,
  input  logic [dist_glob_pkg::WORD_W-1:0] caps_word,
  input  logic [dist_glob_pkg::WORD_W-1:0] ident_word,
  output logic [dist_glob_pkg::WORD_W-1:0] rdata_q
);
  import dist_glob_pkg::*;
  logic [WORD_W-1:0] sel_word;

  always_comb begin
    case (ofs)
      OFS_CTRL:  sel_word = {{(WORD_W-1){1'b0}}, enable};
      OFS_CAPS:  sel_word = caps_word;
      OFS_IDENT: sel_word = ident_word;
      default:   sel_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= sel_word;
  end
endmodule

// File: rtl/dist_glob_regs.sv
module dist_glob_regs #(
  parameter int          ADDR_W       = 4,
  parameter int          NUM_SHARED   = 96,
  parameter int          NUM_CPUS     = 4,
  parameter logic [7:0]  PRODUCT_CODE = 8'h4B,
  parameter logic [11:0] IMPL_CODE    = 12'h43B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              dist_enable,
  output logic              wake_pulse
);
  import dist_glob_pkg::*;

  glob_ofs_e   ofs;
  logic        wr_ctrl;
  logic [31:0] caps_word;
  logic [31:0] ident_word;
  logic        unused_bus_bits;

  assign ofs             = glob_ofs_e'(bus_addr[3:2]);
  assign wr_ctrl         = bus_wr && (ofs == OFS_CTRL);
  assign unused_bus_bits = ^{bus_wdata[31:1], bus_addr[1:0]};

  glob_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_ctrl  (wr_ctrl),
    .wr_bit   (bus_wdata[0]),
    .enable_q (dist_enable),
    .wake_q   (wake_pulse)
  );

  glob_ident_words #(
    .NUM_SHARED   (NUM_SHARED),
    .NUM_CPUS     (NUM_CPUS),
    .PRODUCT_CODE (PRODUCT_CODE),
    .IMPL_CODE    (IMPL_CODE)
  ) u_ident (
    .caps_word  (caps_word),
    .ident_word (ident_word)
  );

  glob_read_port u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd         (bus_rd),
    .ofs        (ofs),
    .enable     (dist_enable),
    .caps_word  (caps_word),
    .ident_word (ident_word),
    .rdata_q    (bus_rdata)
  );
endmodule

// File: rtl/dist_glob_regs_chk.sv
module dist_glob_regs_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              dist_enable,
  input logic              wake_pulse
);
  logic [1:0] sel;
  assign sel = bus_addr[3:2];

  // R1: state is clear right after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!dist_enable && !wake_pulse && bus_rdata == 32'd0));

  // R2: upper control bits always read zero
  a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd) && $past(sel) == 2'd0) |-> bus_rdata[31:1] == 31'd0);

  // R3: pulse only after an off-to-on change
  a_r3_wake_on_rise: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (dist_enable && !$past(dist_enable)));

  // R3: pulse lasts one clock
  a_r3_wake_single: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);

  // R4: no pulse without a control write of a one
  a_r4_wake_needs_write: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> ($past(bus_wr) && $past(sel) == 2'd0 && $past(bus_wdata[0])));

  // R7: enable moves only on a control write
  a_r7_enable_held: assert property (@(posedge clk) disable iff (rst)
    !($past(bus_wr) && $past(sel) == 2'd0) |-> $stable(dist_enable));

  // R8: spare word reads zero
  a_r8_spare_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd) && $past(sel) == 2'd3) |-> bus_rdata == 32'd0);

  // R9: read data holds without a read strobe
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

bind dist_glob_regs dist_glob_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .dist_enable (dist_enable),
  .wake_pulse  (wake_pulse)
);

// File: tb/dist_glob_regs_bench.sv
module dist_glob_regs_bench;
  localparam int CLK_P      = 10;
  localparam int NS         = 96;
  localparam int NC         = 4;
  localparam logic [7:0]  PC = 8'h4B;
  localparam logic [11:0] IC = 12'h43B;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic       dist_enable, wake_pulse;

  int checks = 0;
  int errors = 0;
  logic exp_en = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dist_glob_regs #(.ADDR_W(4), .NUM_SHARED(NS), .NUM_CPUS(NC),
                   .PRODUCT_CODE(PC), .IMPL_CODE(IC)) u_dist_glob_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dist_enable(dist_enable), .wake_pulse(wake_pulse));

  function automatic logic [31:0] exp_word(input logic [1:0] ofs, input logic en);
    case (ofs)
      2'd0:    return {31'd0, en};
      2'd1:    return 32'(((NS + 32) / 32 - 1) | ((NC - 1) << 5));
      2'd2:    return {PC, 12'd0, IC};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge; returns at the next negedge, after the capturing edge.
  task automatic wr(input logic [1:0] ofs, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = {ofs, 2'b00}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] ofs, output logic [31:0] v);
    bus_rd = 1'b1; bus_addr = {ofs, 2'b00};
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic ctrl_write(input logic b, input string req);
    logic exp_wake;
    exp_wake = !exp_en && b;
    wr(2'd0, {$urandom() & 32'hFFFF_FFFE} | 32'(b));
    exp_en = b;
    check(req, 32'(wake_pulse), 32'(exp_wake));
    check(req, 32'(dist_enable), 32'(exp_en));
    @(negedge clk);
    check("R3 pulse width", 32'(wake_pulse), 32'd0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R1 enable in reset", 32'(dist_enable), 32'd0);
    check("R1 wake in reset", 32'(wake_pulse), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 32'd0);
    check("R1 enable after reset", 32'(dist_enable), 32'd0);

    // R9: read strobe low keeps zero data
    @(negedge clk);
    check("R9 hold without read", bus_rdata, 32'd0);

    rd(2'd1, v); check("R5 capability word", v, exp_word(2'd1, exp_en));
    rd(2'd2, v); check("R6 identification word", v, exp_word(2'd2, exp_en));
    rd(2'd3, v); check("R8 spare word", v, 32'd0);
    rd(2'd0, v); check("R2 control off", v, 32'd0);

    // R3/R4: all old/new pairs
    ctrl_write(1'b0, "R4 0->0");
    ctrl_write(1'b1, "R3 0->1");
    rd(2'd0, v); check("R2 control on", v, 32'd1);
    ctrl_write(1'b1, "R4 1->1");
    ctrl_write(1'b0, "R4 1->0");
    ctrl_write(1'b1, "R3 0->1 again");

    // R7: writes elsewhere
    for (int o = 1; o < 4; o++) begin
      wr(2'(o), 32'hFFFF_FFFF);
      check("R7 no wake", 32'(wake_pulse), 32'd0);
      check("R7 enable kept", 32'(dist_enable), 32'(exp_en));
      rd(2'(o), v); check("R7 word unchanged", v, exp_word(2'(o), exp_en));
    end

    // R9: read and control write together return pre-write enable
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 4'h0; bus_wdata = 32'd0;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R9 same-cycle read old value", bus_rdata, 32'd1);
    exp_en = 1'b0;
    check("R9 same-cycle write applied", 32'(dist_enable), 32'd0);
    @(negedge clk);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] ofs;
      ofs = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1) begin
        if (ofs == 2'd0) ctrl_write(1'($urandom()), "R3/R4 random");
        else begin
          wr(ofs, $urandom());
          check("R7 random no wake", 32'(wake_pulse), 32'd0);
          check("R7 random enable", 32'(dist_enable), 32'(exp_en));
        end
      end else begin
        rd(ofs, v);
        check("R2/R5/R6/R8 random read", v, exp_word(ofs, exp_en));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule